// File: doc/BRIEF.md
# Dual-Port Resource Select and Access Qualifier

This block sits at the two host ports of a bidirectional FIFO pair. On each rising edge of its own clock, each port's select lines and control strobes are sampled. The block turns them into a registered, single-cycle access strobe for exactly one resource. Port A has a 3-bit select that reaches a FIFO, a mailbox, an 18-bit mode/control register and four flag-offset registers. Port B has a 1-bit select that reaches only its FIFO or its mailbox. The memories, flags and parity logic that consume the strobes sit outside this block.

An access qualifies only when the port's enable and request are both high. The read/write line then picks the direction: low means write and high means read. A FIFO write at port A loads FIFO 1, and a read at port A drains FIFO 2. Port B has the opposite pairing. When a port writes its FIFO while its own output drivers are enabled, the word on the bus is the one that port is currently reading out of the other FIFO. The block flags this loopback case alongside the write strobe.

Top module: `bfifo_port_sel`

## Requirements
- R1: While rst_n is low, every output strobe is 0. After release, no strobe appears before the first qualified clock edge.
- R2: Port A, select code 0, enable and request high, rw low: a_fifo_wr (load FIFO 1) is 1 for exactly the clock cycle after that edge.
- R3: Port A, select code 0, enable and request high, rw high: a_fifo_rd (drain FIFO 2) is 1 for the cycle after that edge.
- R4: Port A, select code 1: a_mbox_wr (rw low) or a_mbox_rd (rw high) is 1 for the cycle after the edge.
- R5: Port A register codes map to one-hot bit positions of a_reg_wr / a_reg_rd. Code 2 is the control register (bit 0). Code 4 is offset 0 (bit 1), code 5 is offset 1 (bit 2), code 6 is offset 2 (bit 3) and code 7 is offset 3 (bit 4). rw low drives a_reg_wr and rw high drives a_reg_rd.
- R6: Port A select code 3 has no resource. It produces no strobe at all.
- R7: If enable or request is low at an edge, that port produces no strobe in the following cycle, whatever the select and rw values are.
- R8: Port B, select 0: b_fifo_wr (load FIFO 2) for rw low, or b_fifo_rd (drain FIFO 1) for rw high. Select 1: b_mbox_wr for rw low, or b_mbox_rd for rw high.
- R9: The loopback flag of a port is 1 exactly when that port issues a FIFO write and its out_en input was high at the same edge. It is 0 on reads and on every other access.
- R10: Each port raises at most one of its access strobes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous reset, active low, both domains |
| a_en | input | 1 | Port A enable |
| a_req | input | 1 | Port A request |
| a_rw | input | 1 | Port A direction, 1 = read, 0 = write |
| a_sel | input | 3 | Port A resource select code |
| a_out_en | input | 1 | Port A output drivers enabled |
| b_en | input | 1 | Port B enable |
| b_req | input | 1 | Port B request |
| b_rw | input | 1 | Port B direction, 1 = read, 0 = write |
| b_sel | input | 1 | Port B select, 0 = FIFO, 1 = mailbox |
| b_out_en | input | 1 | Port B output drivers enabled |
| a_fifo_wr | output | 1 | Load FIFO 1 |
| a_fifo_rd | output | 1 | Drain FIFO 2 |
| a_mbox_wr | output | 1 | Port A mailbox write |
| a_mbox_rd | output | 1 | Port A mailbox read |
| a_reg_wr | output | 5 | Port A register write, one-hot |
| a_reg_rd | output | 5 | Port A register read, one-hot |
| a_loop | output | 1 | Port A loopback write |
| b_fifo_wr | output | 1 | Load FIFO 2 |
| b_fifo_rd | output | 1 | Drain FIFO 1 |
| b_mbox_wr | output | 1 | Port B mailbox write |
| b_mbox_rd | output | 1 | Port B mailbox read |
| b_loop | output | 1 | Port B loopback write |

## Verification
The assertions assume that each port's inputs hold steady across that port's rising edge. They also assume the reset is released away from either clock edge, so each output reflects only the inputs captured at the previous edge of its own clock. The bench changes port A inputs only on falling edges of clk_a and port B inputs only on falling edges of clk_b. It releases reset at an instant that matches no edge of either clock. The two clocks have unrelated periods, so the stimulus covers every phase relation between the domains while each domain still sees clean setup.

// File: rtl/bfps_pkg.sv
package bfps_pkg;
  localparam int A_SEL_W = 3;
  localparam int B_SEL_W = 1;
  localparam int NREG    = 5;

  typedef enum logic [A_SEL_W-1:0] {
    SA_FIFO = 3'd0,
    SA_MBOX = 3'd1,
    SA_CTRL = 3'd2,
    SA_NONE = 3'd3,
    SA_OFS0 = 3'd4,
    SA_OFS1 = 3'd5,
    SA_OFS2 = 3'd6,
    SA_OFS3 = 3'd7
  } sel_a_e;

  typedef struct packed {
    logic loop;
    logic fifo_wr;
    logic fifo_rd;
    logic mbox_wr;
    logic mbox_rd;
  } port_strb_t;

  // register slot for a port A code; all zeros when code is not a register
  function automatic logic [NREG-1:0] reg_slot(input logic [A_SEL_W-1:0] code);
    logic [NREG-1:0] r;
    r = '0;
    case (sel_a_e'(code))
      SA_CTRL: r[0] = 1'b1;
      SA_OFS0: r[1] = 1'b1;
      SA_OFS1: r[2] = 1'b1;
      SA_OFS2: r[3] = 1'b1;
      SA_OFS3: r[4] = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bfps_qual.sv
module bfps_qual (
  input  logic en,
  input  logic req,
  input  logic rw,
  output logic wr_go,
  output logic rd_go
);
  logic live;
  assign live  = en & req;
  assign wr_go = live & ~rw;
  assign rd_go = live & rw;
endmodule

// File: rtl/bfps_dec_a.sv
module bfps_dec_a
  import bfps_pkg::*;
(
  input  logic [A_SEL_W-1:0] sel,
  input  logic               wr_go,
  input  logic               rd_go,
  input  logic               out_en,
  output port_strb_t         strb,
  output logic [NREG-1:0]    reg_wr,
  output logic [NREG-1:0]    reg_rd
);
  logic [NREG-1:0] slot;
  logic is_fifo, is_mbox;

  assign slot    = reg_slot(sel);
  assign is_fifo = (sel == SA_FIFO);
  assign is_mbox = (sel == SA_MBOX);

  always_comb begin
    strb         = '0;
    strb.fifo_wr = is_fifo & wr_go;
    strb.fifo_rd = is_fifo & rd_go;
    strb.mbox_wr = is_mbox & wr_go;
    strb.mbox_rd = is_mbox & rd_go;
    strb.loop    = is_fifo & wr_go & out_en;
  end

  assign reg_wr = slot & {NREG{wr_go}};
  assign reg_rd = slot & {NREG{rd_go}};
endmodule

// File: rtl/bfps_dec_b.sv
module bfps_dec_b
  import bfps_pkg::*;
(
  input  logic [B_SEL_W-1:0] sel,
  input  logic               wr_go,
  input  logic               rd_go,
  input  logic               out_en,
  output port_strb_t         strb
);
  logic is_fifo;
  assign is_fifo = (sel == '0);

  always_comb begin
    strb         = '0;
    strb.fifo_wr = is_fifo & wr_go;
    strb.fifo_rd = is_fifo & rd_go;
    strb.mbox_wr = ~is_fifo & wr_go;
    strb.mbox_rd = ~is_fifo & rd_go;
    strb.loop    = is_fifo & wr_go & out_en;
  end
endmodule

// File: rtl/bfifo_port_sel.sv
module bfifo_port_sel
  import bfps_pkg::*;
(
  input  logic               clk_a,
  input  logic               clk_b,
  input  logic               rst_n,
  input  logic               a_en,
  input  logic               a_req,
  input  logic               a_rw,
  input  logic [A_SEL_W-1:0] a_sel,
  input  logic               a_out_en,
  input  logic               b_en,
  input  logic               b_req,
  input  logic               b_rw,
  input  logic [B_SEL_W-1:0] b_sel,
  input  logic               b_out_en,
  output logic               a_fifo_wr,
  output logic               a_fifo_rd,
  output logic               a_mbox_wr,
  output logic               a_mbox_rd,
  output logic [NREG-1:0]    a_reg_wr,
  output logic [NREG-1:0]    a_reg_rd,
  output logic               a_loop,
  output logic               b_fifo_wr,
  output logic               b_fifo_rd,
  output logic               b_mbox_wr,
  output logic               b_mbox_rd,
  output logic               b_loop
);
  // ---------------- port A ----------------
  logic            a_wr_go, a_rd_go;
  port_strb_t      a_nxt, a_q;
  logic [NREG-1:0] a_rw_nxt, a_rr_nxt, a_rw_q, a_rr_q;

  bfps_qual u_qual_a (.en(a_en), .req(a_req), .rw(a_rw),
                      .wr_go(a_wr_go), .rd_go(a_rd_go));

  bfps_dec_a u_dec_a (.sel(a_sel), .wr_go(a_wr_go), .rd_go(a_rd_go),
                      .out_en(a_out_en), .strb(a_nxt),
                      .reg_wr(a_rw_nxt), .reg_rd(a_rr_nxt));

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      a_rw_q <= '0;
      a_rr_q <= '0;
    end else begin
      a_q    <= a_nxt;
      a_rw_q <= a_rw_nxt;
      a_rr_q <= a_rr_nxt;
    end
  end

  assign a_fifo_wr = a_q.fifo_wr;
  assign a_fifo_rd = a_q.fifo_rd;
  assign a_mbox_wr = a_q.mbox_wr;
  assign a_mbox_rd = a_q.mbox_rd;
  assign a_loop    = a_q.loop;
  assign a_reg_wr  = a_rw_q;
  assign a_reg_rd  = a_rr_q;

  // ---------------- port B ----------------
  logic       b_wr_go, b_rd_go;
  port_strb_t b_nxt, b_q;

  bfps_qual u_qual_b (.en(b_en), .req(b_req), .rw(b_rw),
                      .wr_go(b_wr_go), .rd_go(b_rd_go));

  bfps_dec_b u_dec_b (.sel(b_sel), .wr_go(b_wr_go), .rd_go(b_rd_go),
                      .out_en(b_out_en), .strb(b_nxt));

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) b_q <= '0;
    else        b_q <= b_nxt;
  end

  assign b_fifo_wr = b_q.fifo_wr;
  assign b_fifo_rd = b_q.fifo_rd;
  assign b_mbox_wr = b_q.mbox_wr;
  assign b_mbox_rd = b_q.mbox_rd;
  assign b_loop    = b_q.loop;

  // ---------------- assertions ----------------
  AST_RESET_QUIET: assert property (@(posedge clk_a) !rst_n |-> !(a_fifo_wr | a_fifo_rd | a_mbox_wr | a_mbox_rd | a_loop)); // R1
  AST_A_FIFO_WR_QUAL: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(a_fifo_wr) |-> $past(a_en && a_req && !a_rw && a_sel == SA_FIFO)); // R2
  AST_A_FIFO_RD_QUAL: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(a_fifo_rd) |-> $past(a_en && a_req && a_rw && a_sel == SA_FIFO)); // R3
  AST_A_MBOX_SEL: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(a_mbox_wr | a_mbox_rd) |-> $past(a_sel == SA_MBOX)); // R4
  AST_A_REG_ONEHOT: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0({a_reg_wr, a_reg_rd})); // R5
  AST_A_NO_RESOURCE: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_sel == SA_NONE) |=> !(a_fifo_wr | a_fifo_rd | a_mbox_wr | a_mbox_rd | (|a_reg_wr) | (|a_reg_rd))); // R6
  AST_A_IDLE: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(a_en && a_req) |=> !(a_fifo_wr | a_fifo_rd | a_mbox_wr | a_mbox_rd | (|a_reg_wr) | (|a_reg_rd))); // R7
  AST_B_IDLE: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(b_en && b_req) |=> !(b_fifo_wr | b_fifo_rd | b_mbox_wr | b_mbox_rd)); // R7
  AST_B_MBOX_SEL: assert property (@(posedge clk_b) disable iff (!rst_n)
    $rose(b_mbox_wr | b_mbox_rd) |-> $past(b_sel == 1'b1)); // R8
  AST_A_LOOP_WR: assert property (@(posedge clk_a) disable iff (!rst_n) a_loop |-> a_fifo_wr); // R9
  AST_B_LOOP_WR: assert property (@(posedge clk_b) disable iff (!rst_n) b_loop |-> b_fifo_wr); // R9
  AST_A_ONE_ACCESS: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0({a_fifo_wr, a_fifo_rd, a_mbox_wr, a_mbox_rd, a_reg_wr, a_reg_rd})); // R10
  AST_B_ONE_ACCESS: assert property (@(posedge clk_b) disable iff (!rst_n)
    $onehot0({b_fifo_wr, b_fifo_rd, b_mbox_wr, b_mbox_rd})); // R10
endmodule

// File: tb/test_bfifo_port_sel.sv
module test_bfifo_port_sel;
  localparam int TCLK_A   = 10;
  localparam int TCLK_B   = 14;
  localparam int A_CYCLES = 3000;
  localparam int WATCHDOG = 100000;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_en = 0, a_req = 0, a_rw = 0, a_out_en = 0;
  logic [2:0] a_sel = '0;
  logic b_en = 0, b_req = 0, b_rw = 0, b_out_en = 0;
  logic [0:0] b_sel = '0;
  logic a_fifo_wr, a_fifo_rd, a_mbox_wr, a_mbox_rd, a_loop;
  logic [4:0] a_reg_wr, a_reg_rd;
  logic b_fifo_wr, b_fifo_rd, b_mbox_wr, b_mbox_rd, b_loop;

  int n_tests = 0, n_fail = 0;
  int cyc_a = 0, cyc_b = 0;
  bit done = 0;

  logic [14:0] qa[$];
  string       ta[$];
  logic [4:0]  qb[$];
  string       tb_tag[$];

  always #(TCLK_A/2) clk_a = ~clk_a;
  always #(TCLK_B/2) clk_b = ~clk_b;

  bfifo_port_sel i_bfifo_port_sel (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_en(a_en), .a_req(a_req), .a_rw(a_rw), .a_sel(a_sel), .a_out_en(a_out_en),
    .b_en(b_en), .b_req(b_req), .b_rw(b_rw), .b_sel(b_sel), .b_out_en(b_out_en),
    .a_fifo_wr(a_fifo_wr), .a_fifo_rd(a_fifo_rd), .a_mbox_wr(a_mbox_wr), .a_mbox_rd(a_mbox_rd),
    .a_reg_wr(a_reg_wr), .a_reg_rd(a_reg_rd), .a_loop(a_loop),
    .b_fifo_wr(b_fifo_wr), .b_fifo_rd(b_fifo_rd), .b_mbox_wr(b_mbox_wr), .b_mbox_rd(b_mbox_rd),
    .b_loop(b_loop)
  );

  task automatic check(input string tag, input logic [14:0] got, input logic [14:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // reference model, port A: {loop, fifo_wr, fifo_rd, mbox_wr, mbox_rd, reg_wr[5], reg_rd[5]}
  always @(posedge clk_a) begin
    logic [14:0] e;
    string t;
    int slot;
    e = '0;
    if (!rst_n) t = "R1";
    else if (!(a_en && a_req)) t = "R7";
    else begin
      case (int'(a_sel))
        0: begin
          if (a_rw) begin e[12] = 1; t = "R3"; end
          else begin e[13] = 1; e[14] = a_out_en; t = a_out_en ? "R9" : "R2"; end
        end
        1: begin if (a_rw) e[10] = 1; else e[11] = 1; t = "R4"; end
        3: t = "R6";
        default: begin
          slot = (a_sel == 3'd2) ? 0 : int'(a_sel) - 3;
          if (a_rw) e[slot] = 1; else e[5 + slot] = 1;
          t = "R5";
        end
      endcase
    end
    qa.push_back(e);
    ta.push_back(t);
  end

  always @(posedge clk_b) begin
    logic [4:0] e;
    string t;
    e = '0;
    if (!rst_n) t = "R1";
    else if (!(b_en && b_req)) t = "R7";
    else begin
      if (b_sel == 1'b0) begin
        if (b_rw) e[2] = 1; else begin e[3] = 1; e[4] = b_out_en; end
        t = (!b_rw && b_out_en) ? "R9" : "R8";
      end else begin
        if (b_rw) e[0] = 1; else e[1] = 1;
        t = "R8";
      end
    end
    qb.push_back(e);
    tb_tag.push_back(t);
  end

  // compare and drive on falling edges
  always @(negedge clk_a) begin
    logic [14:0] got;
    got = {a_loop, a_fifo_wr, a_fifo_rd, a_mbox_wr, a_mbox_rd, a_reg_wr, a_reg_rd};
    if (!rst_n) check("R1", got, 15'd0);
    if (qa.size() > 0) begin
      logic [14:0] e;
      string t;
      e = qa.pop_front();
      t = ta.pop_front();
      if (rst_n) check(t, got, e);
      n_tests++;
      if ($countones(got[13:0]) > 1) begin
        n_fail++;
        $display("FAIL R10: port A strobes %b expected at most one set", got);
      end
    end
    cyc_a++;
    if (cyc_a < 300) begin
      {a_en, a_req, a_rw, a_sel} = 6'(cyc_a);
      a_out_en = cyc_a[6];
      if (cyc_a >= 64) {a_en, a_req} = 2'b11;
    end else begin
      a_en = ($urandom_range(0, 7) != 0);
      a_req = ($urandom_range(0, 7) != 0);
      a_rw = 1'($urandom);
      a_sel = 3'($urandom);
      a_out_en = 1'($urandom);
    end
    if (cyc_a >= A_CYCLES) done = 1;
  end

  always @(negedge clk_b) begin
    logic [4:0] got;
    got = {b_loop, b_fifo_wr, b_fifo_rd, b_mbox_wr, b_mbox_rd};
    if (!rst_n) check("R1", {10'd0, got}, 15'd0);
    if (qb.size() > 0) begin
      logic [4:0] e;
      string t;
      e = qb.pop_front();
      t = tb_tag.pop_front();
      if (rst_n) check(t, {10'd0, got}, {10'd0, e});
      n_tests++;
      if ($countones(got[3:0]) > 1) begin
        n_fail++;
        $display("FAIL R10: port B strobes %b expected at most one set", got);
      end
    end
    cyc_b++;
    if (cyc_b < 200) begin
      {b_out_en, b_en, b_req, b_rw, b_sel} = 5'(cyc_b);
      if (cyc_b >= 32) {b_en, b_req} = 2'b11;
    end else begin
      b_en = ($urandom_range(0, 5) != 0);
      b_req = ($urandom_range(0, 5) != 0);
      b_rw = 1'($urandom);
      b_sel = 1'($urandom);
      b_out_en = 1'($urandom);
    end
  end

  initial begin
    // R1: strobes held low while reset is applied with live stimulus
    #202 rst_n = 1'b1;
    wait (done);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(WATCHDOG * TCLK_A);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule